// File: doc/BRIEF.md
# Shared GPIO Port with Peripheral Override

This block is an 8-bit general-purpose I/O port whose pads are also used by two serial receive/transmit channels and a synchronous serial (SPI) interface. Software sees two registers, a data latch and a direction register. Each has its own write strobe and a common write data bus. Each pad has a tri-state output made of an output value and an output enable, and an input level. The input level passes through a synchronizer before it can be read back.

Each pin has one fixed peripheral function. The pin index order matters because the override logic decodes it. Index 0 is receive for channel 0 and index 1 is transmit for channel 0. Index 2 is receive for channel 1 and index 3 is transmit for channel 1. Index 4 is MISO, 5 is MOSI, 6 is SCK and 7 is slave select. Each peripheral supplies a per-pin enable, plus an output value and output enable for the pins it can drive. While a peripheral owns a pin that can be driven, the peripheral controls the pad in place of the latch. Latch writes are still stored and take effect on the pad once the peripheral releases the pin. The two receive pins are never driven while their peripheral owns them.

Top module: `gpio_share_port`

## Requirements
- R1: After reset the direction readback `dir_rd` is 8'h00 and `pad_oe` is 8'h00, so every pad floats.
- R2: A `data_wr` pulse stores `wdata` in the latch whatever the direction. A pin with direction 1 and no peripheral ownership then drives `pad_oe`=1 and `pad_out` equal to its latch bit. A pin with direction 0 leaves `pad_oe`=0.
- R3: A `dir_wr` pulse stores `wdata` as the direction, and `dir_rd` returns it after the clock edge. A direction bit of 1 means output.
- R4: A pin whose `pad_oe` is 0 reads back through a two-stage synchronizer. A change on `pad_in` appears on `data_rd` after the second rising clock edge, and not after the first.
- R5: A pin whose `pad_oe` is 1 reads back its `pad_out` value, not the `pad_in` level.
- R6: On pins 1, 3, 4, 5, 6 and 7 (transmit 0, transmit 1, MISO, MOSI, SCK, slave select), `periph_en`=1 makes `pad_out` follow `periph_out` and `pad_oe` follow `periph_oe`, whatever the direction bit.
- R7: A latch write while a peripheral owns a pin has no effect on that pad. When `periph_en` drops, the pad shows the last written latch bit.
- R8: On pins 0 and 2 (receive 0, receive 1), `periph_en`=1 forces `pad_oe`=0 even when the direction bit is 1, so the pin reads the synchronized pad level.
- R9: When `data_wr` and `dir_wr` are pulsed in the same cycle, both registers take `wdata` on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_wr | input | 1 | Write strobe for the data latch |
| dir_wr | input | 1 | Write strobe for the direction register |
| wdata | input | 8 | Write data for both registers |
| data_rd | output | 8 | Per-pin readback: driven value or synchronized pad level |
| dir_rd | output | 8 | Direction register readback |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |
| periph_en | input | 8 | Per-pin peripheral ownership |
| periph_out | input | 8 | Peripheral output values |
| periph_oe | input | 8 | Peripheral output enables |

## Verification
The bench samples the readback after exactly one edge and after two edges following a pad change. A synchronizer with the wrong depth shows the new level one cycle early or late. It writes the latch while peripherals own the pins and then releases them. A design that lets the write reach the pad, or that drops the write, shows the wrong `pad_out` at one of the two checks. It sets the direction bits on the receive pins while their peripherals own them, which catches a design that drives a receive pad. It also mixes driven and floating pins in one readback, which shows whether the read select follows the real output enable.

// File: rtl/gpio_share_pkg.sv
package gpio_share_pkg;
    localparam int PORT_W = 8;

    // pin roles by index; the override decode depends on this order
    localparam int PIN_RX0  = 0;
    localparam int PIN_TX0  = 1;
    localparam int PIN_RX1  = 2;
    localparam int PIN_TX1  = 3;
    localparam int PIN_MISO = 4;
    localparam int PIN_MOSI = 5;
    localparam int PIN_SCK  = 6;
    localparam int PIN_SS   = 7;

    // pins whose peripheral may drive the pad
    localparam logic [PORT_W-1:0] DRIVE_MASK =
        PORT_W'((1 << PIN_TX0) | (1 << PIN_TX1) | (1 << PIN_MISO) |
                (1 << PIN_MOSI) | (1 << PIN_SCK) | (1 << PIN_SS));
endpackage

// File: rtl/gpio_share_regs.sv
module gpio_share_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         data_wr,
    input  logic         dir_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] latch_q,
    output logic [W-1:0] dir_q
);
    typedef struct packed {
        logic [W-1:0] latch;
        logic [W-1:0] dir;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (data_wr) r_d.latch = wdata;
        if (dir_wr)  r_d.dir   = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign latch_q = r_q.latch;
    assign dir_q   = r_q.dir;

    // R3: direction takes the written value one edge later
    p_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> (dir_q == $past(wdata)));

    // R2: latch holds without a write strobe
    p_latch_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> $stable(latch_q));
endmodule

// File: rtl/gpio_share_sync.sv
module gpio_share_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] level
);
    localparam int CW = $clog2(STAGES + 1);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stage;
        logic [CW-1:0]            warm;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.stage[0] = async_in;
        for (int k = 1; k < STAGES; k++) begin
            s_d.stage[k] = s_q.stage[k-1];
        end
        if (s_q.warm != CW'(STAGES)) s_d.warm = s_q.warm + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level = s_q.stage[STAGES-1];

    generate
        if (STAGES >= 2) begin : g_chk
            // R4: the last stage always carries the previous stage's value
            p_sync_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (s_q.warm != '0) |=> (level == $past(s_q.stage[STAGES-2])));
        end
    endgenerate
endmodule

// File: rtl/gpio_share_pinmux.sv
module gpio_share_pinmux #(
    parameter int           W    = 8,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic [W-1:0] latch,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] sync_lvl,
    input  logic [W-1:0] periph_en,
    input  logic [W-1:0] periph_out,
    input  logic [W-1:0] periph_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] rd_val
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            if (MASK[i]) begin : g_drive
                // peripheral may own the driver
                always_comb begin
                    if (periph_en[i]) begin
                        pad_out[i] = periph_out[i];
                        pad_oe[i]  = periph_oe[i];
                    end else begin
                        pad_out[i] = latch[i];
                        pad_oe[i]  = dir[i];
                    end
                end
            end else begin : g_recv
                // receive function: owning peripheral forces the pin to input
                always_comb begin
                    pad_out[i] = latch[i];
                    pad_oe[i]  = dir[i] & ~periph_en[i];
                end
            end
            assign rd_val[i] = pad_oe[i] ? pad_out[i] : sync_lvl[i];
        end
    endgenerate
endmodule

// File: rtl/gpio_share_port.sv
module gpio_share_port
    import gpio_share_pkg::*;
#(
    parameter int                WIDTH       = PORT_W,
    parameter int                SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0]  OVR_MASK    = DRIVE_MASK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             data_wr,
    input  logic             dir_wr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] data_rd,
    output logic [WIDTH-1:0] dir_rd,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    input  logic [WIDTH-1:0] periph_en,
    input  logic [WIDTH-1:0] periph_out,
    input  logic [WIDTH-1:0] periph_oe
);
    logic [WIDTH-1:0] latch_q, dir_q, sync_lvl;

    gpio_share_regs #(.W(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .dir_wr(dir_wr),
        .wdata(wdata), .latch_q(latch_q), .dir_q(dir_q)
    );

    gpio_share_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .level(sync_lvl)
    );

    gpio_share_pinmux #(.W(WIDTH), .MASK(OVR_MASK)) u_mux (
        .latch(latch_q), .dir(dir_q), .sync_lvl(sync_lvl),
        .periph_en(periph_en), .periph_out(periph_out), .periph_oe(periph_oe),
        .pad_out(pad_out), .pad_oe(pad_oe), .rd_val(data_rd)
    );

    assign dir_rd = dir_q;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_chk
            if (!OVR_MASK[i]) begin : g_rx
                // R8: an owned receive pin never drives
                p_rx_float_r8: assert property (@(posedge clk) disable iff (!rst_n)
                    periph_en[i] |-> !pad_oe[i]);
            end else begin : g_tx
                // R6: an owned drive pin follows the peripheral enable
                p_owned_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
                    periph_en[i] |-> (pad_oe[i] == periph_oe[i]));
            end
        end
    endgenerate
endmodule

// File: tb/gpio_share_port_test.sv
`timescale 1ns/1ps
module gpio_share_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       data_wr = 1'b0, dir_wr = 1'b0;
    logic [7:0] wdata = '0, pad_in = '0, periph_en = '0, periph_out = '0, periph_oe = '0;
    logic [7:0] data_rd, dir_rd, pad_out, pad_oe;

    int checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    gpio_share_port uut (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .dir_wr(dir_wr),
        .wdata(wdata), .data_rd(data_rd), .dir_rd(dir_rd), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .periph_en(periph_en),
        .periph_out(periph_out), .periph_oe(periph_oe)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // inputs change and outputs are sampled at the falling edge
    task automatic wr(input logic dat, input logic dr, input logic [7:0] v);
        @(negedge clk);
        data_wr = dat; dir_wr = dr; wdata = v;
        @(negedge clk);
        data_wr = 1'b0; dir_wr = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 dir_rd", dir_rd, 8'h00);
        chk("R1 pad_oe", pad_oe, 8'h00);
    endtask

    task automatic t_latch_dir;
        wr(1, 0, 8'h96);
        chk("R2 oe with dir 0", pad_oe, 8'h00);
        wr(0, 1, 8'hFF);
        chk("R3 dir_rd", dir_rd, 8'hFF);
        chk("R2 pad_out", pad_out, 8'h96);
        chk("R2 pad_oe", pad_oe, 8'hFF);
    endtask

    task automatic t_sync;
        wr(0, 1, 8'h00);
        settle(3);
        @(negedge clk); pad_in = 8'hA5;
        @(negedge clk);
        chk("R4 after one edge", data_rd, 8'h00);
        @(negedge clk);
        chk("R4 after two edges", data_rd, 8'hA5);
    endtask

    task automatic t_out_read;
        wr(1, 1, 8'h0F);
        settle(2);
        chk("R5 mixed read", data_rd, 8'hAF);
        chk("R9 dir", dir_rd, 8'h0F);
        chk("R9 pad_out", pad_out, 8'h0F);
        wr(1, 1, 8'h3C);
        chk("R9 both regs", {pad_oe[7:4], pad_out[3:0]}, 8'h3C);
    endtask

    task automatic t_override;
        pad_in = 8'h00;
        wr(1, 1, 8'hFF);
        wr(1, 0, 8'h00);
        settle(2);
        @(negedge clk);
        periph_en = 8'hFA; periph_out = 8'hFF; periph_oe = 8'hF0;
        #1;
        chk("R6 pad_oe", pad_oe, 8'hF5);
        chk("R6 pad_out", pad_out, 8'hFA);
        chk("R5 read owned", data_rd, 8'hF0);
        wr(1, 0, 8'h5A);
        chk("R7 pad_out unchanged", pad_out, 8'hFA);
        chk("R7 pad_oe unchanged", pad_oe, 8'hF5);
        @(negedge clk); periph_en = 8'h00; #1;
        chk("R7 released pad_out", pad_out, 8'h5A);
        chk("R7 released pad_oe", pad_oe, 8'hFF);
        chk("R7 released read", data_rd, 8'h5A);
    endtask

    task automatic t_rx;
        @(negedge clk);
        periph_oe = 8'hFF; periph_en = 8'h05; pad_in = 8'h05;
        #1;
        chk("R8 pad_oe", pad_oe, 8'hFA);
        settle(2);
        chk("R8 read", data_rd, 8'h5F);
        @(negedge clk); periph_en = 8'h00;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        settle(3);
        t_reset();
        rst_n = 1'b1;
        settle(1);
        t_reset();
        t_latch_dir();
        t_sync();
        t_out_read();
        t_override();
        t_rx();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule